// File: doc/BRIEF.md
# Board Configuration Transaction Engine

This block carries out single configuration transactions against a small set of on-board devices: motherboard and daughterboard oscillators, daughterboard voltage sensors, a fixed motherboard supply sensor, and a few motherboard control functions. Software programs a data word and a control word. Writing the control word with its start bit set launches one transaction. The engine decodes the packed addressing fields, and in the next cycle it records completion and error in a sticky status register. A read returns its result in the data register. A write takes its operand from the data register.

Two of the control functions request a system shutdown or a system reboot. Each request appears as a one-cycle pulse on its own output. The three registers sit at byte offsets 0xA0 (data), 0xA4 (control) and 0xA8 (status). A strap input says whether this board variant has the registers at all. When it does not, the registers read as zero and ignore writes.

Top module: `cfg_xact_engine`

## Requirements
- R1: After reset, the data, control and status registers read 0, both request outputs are low, and the six motherboard oscillators hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000.
- R2: The control register stores the written word with bit 31 and bits 19:18 forced to zero. A control write with bit 31 clear launches nothing and leaves status unchanged.
- R3: A control write with bit 31 set launches a transaction. On the next clock edge, status becomes 1 (bit 0 = complete) if the transaction is supported, or 3 (bit 1 = error) if it is not. Control field layout: bit 30 = write, [29:26] = controller, [25:20] = function, [17:16] = site, [15:12] = position, [11:0] = device.
- R4: A transaction is an error if the controller is nonzero, the position is nonzero, the site is 2 or 3, or the function is unsupported (for example 3).
- R5: Function 1 at site 0 reads or writes motherboard oscillators 0 to 5. Device 6 or higher is an error.
- R6: Function 1 at site 1 reads or writes DB_OSC_N daughterboard oscillators, which reset to DB_OSC_INIT. A device index of DB_OSC_N or higher is an error.
- R7: Function 2 is read-only. Site 0, device 0 returns 3300000. Site 1, device d below DB_VOLT_N returns entry d of DB_VOLT. Any write, or any other device, is an error.
- R8: Functions 7, 8, 9 and 11 are write-only and succeed only at site 0, device 0. A successful function 8 pulses shutdown_req for exactly one cycle, and a successful function 9 pulses reboot_req for one cycle, both on the completion edge. Failed transactions pulse nothing.
- R9: A successful read stores its result in the data register. A failed read leaves the data register unchanged. A write transaction uses the value the data register holds at completion.
- R10: A software write to the status register stores bits 1:0 of the written word.
- R11: In the completion cycle, the transaction's status update takes priority over a software status write. A read result also takes priority over a software data write. When the completion does not store data, the software data write takes effect.
- R12: With cfg_present low, all three registers read 0, and writes (including launches) change nothing and pulse no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_present | input | 1 | Strap: registers exist on this board variant |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The completion of a launched transaction and a software write to the data or status register can land on the same clock edge. The bench provokes this by issuing the register write in the cycle right after the launching control write. For a successful read, it expects the transaction's result in the data register and status 1. For an erroring transaction, it expects status 3 but the software data value in the data register. A launch made while the variant strap is low is also checked: it must leave the registers unchanged and produce no request pulse.

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine #(
  parameter int AW = 12,
  parameter int DB_OSC_N = 2,
  parameter int DB_VOLT_N = 2,
  parameter logic [DB_OSC_N*32-1:0] DB_OSC_INIT = {32'd45000000, 32'd30000000},
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT = {32'd1000000, 32'd900000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_present,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          shutdown_req,
  output logic          reboot_req
);
  localparam int MB_OSC_N = 6;
  localparam int DOW = (DB_OSC_N > 1) ? $clog2(DB_OSC_N) : 1;
  localparam int DVW = (DB_VOLT_N > 1) ? $clog2(DB_VOLT_N) : 1;
  localparam logic [AW-1:0] A_DATA = AW'('hA0);
  localparam logic [AW-1:0] A_CTRL = AW'('hA4);
  localparam logic [AW-1:0] A_STAT = AW'('hA8);
  localparam logic [31:0] CTRL_ZERO = 32'h800C_0000;
  localparam logic [31:0] MB_SUPPLY = 32'd3300000;

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic        pend_q;
  logic [31:0] mb_osc [MB_OSC_N];
  logic [31:0] db_osc [DB_OSC_N];

  wire wr_acc  = cfg_present && bus_sel && bus_wr;
  wire wr_data = wr_acc && bus_addr == A_DATA;
  wire wr_ctrl = wr_acc && bus_addr == A_CTRL;
  wire wr_stat = wr_acc && bus_addr == A_STAT;

  wire        is_wr = ctrl_q[30];
  wire [3:0]  dcc   = ctrl_q[29:26];
  wire [5:0]  fn    = ctrl_q[25:20];
  wire [1:0]  site  = ctrl_q[17:16];
  wire [3:0]  pos   = ctrl_q[15:12];
  wire [11:0] dev   = ctrl_q[11:0];

  logic        ok;
  logic [31:0] rval;

  always_comb begin
    ok = 1'b0;
    rval = 32'd0;
    if (dcc == 4'd0 && pos == 4'd0 && site < 2'd2) begin
      case (fn)
        6'd1: begin
          if (site == 2'd0 && dev < 12'd6) begin
            ok = 1'b1;
            rval = mb_osc[dev[2:0]];
          end else if (site == 2'd1 && 32'(dev) < DB_OSC_N) begin
            ok = 1'b1;
            rval = db_osc[dev[DOW-1:0]];
          end
        end
        6'd2: begin
          if (!is_wr && site == 2'd0 && dev == 12'd0) begin
            ok = 1'b1;
            rval = MB_SUPPLY;
          end else if (!is_wr && site == 2'd1 && 32'(dev) < DB_VOLT_N) begin
            ok = 1'b1;
            rval = DB_VOLT[dev[DVW-1:0]*32 +: 32];
          end
        end
        6'd7, 6'd8, 6'd9, 6'd11: ok = is_wr && site == 2'd0 && dev == 12'd0;
        default: ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      pend_q <= 1'b0;
      shutdown_req <= 1'b0;
      reboot_req <= 1'b0;
      mb_osc[0] <= 32'd50000000;
      mb_osc[1] <= 32'd23750000;
      for (int i = 2; i < MB_OSC_N; i++) mb_osc[i] <= 32'd24000000;
      for (int i = 0; i < DB_OSC_N; i++) db_osc[i] <= DB_OSC_INIT[i*32 +: 32];
    end else begin
      shutdown_req <= 1'b0;
      reboot_req <= 1'b0;
      pend_q <= 1'b0;
      if (wr_data) data_q <= bus_wdata;
      if (wr_stat) stat_q <= bus_wdata[1:0];
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata & ~CTRL_ZERO;
        pend_q <= bus_wdata[31];
      end
      if (pend_q) begin
        stat_q <= {~ok, 1'b1};
        if (ok && !is_wr) data_q <= rval;
        if (ok && is_wr && fn == 6'd1) begin
          if (site == 2'd0) mb_osc[dev[2:0]] <= data_q;
          else db_osc[dev[DOW-1:0]] <= data_q;
        end
        shutdown_req <= ok && is_wr && fn == 6'd8;
        reboot_req   <= ok && is_wr && fn == 6'd9;
      end
    end
  end

  assign bus_rdata = !cfg_present       ? 32'd0 :
                     bus_addr == A_DATA ? data_q :
                     bus_addr == A_CTRL ? ctrl_q :
                     bus_addr == A_STAT ? {30'd0, stat_q} : 32'd0;
endmodule

// File: rtl/cfg_xact_engine_chk.sv
module cfg_xact_engine_chk #(parameter int AW = 12) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_present,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          shutdown_req,
  input logic          reboot_req,
  input logic          pend_q,
  input logic [1:0]    stat_q
);
  localparam logic [AW-1:0] A_CTRL = AW'('hA4);
  localparam logic [AW-1:0] A_STAT = AW'('hA8);

  p_ctrl_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == A_CTRL |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

  p_done_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> stat_q[0]);

  p_shutdown_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  p_reboot_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);

  p_req_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |-> $past(pend_q));

  p_stat_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_present && bus_sel && bus_wr && bus_addr == A_STAT && !pend_q)
      |=> stat_q == $past(bus_wdata[1:0]));

  p_absent_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_present |-> bus_rdata == 32'd0);
endmodule

bind cfg_xact_engine cfg_xact_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_present(cfg_present), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .shutdown_req(shutdown_req), .reboot_req(reboot_req),
  .pend_q(pend_q), .stat_q(stat_q)
);

// File: tb/test_cfg_xact_engine.sv
module test_cfg_xact_engine;
  logic clk = 1'b0, rst_n = 1'b0, cfg_present = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic shutdown_req, reboot_req;
  int total = 0, bad = 0;
  logic seen_sd, seen_rb;
  logic [31:0] rd;

  localparam logic [11:0] AD = 12'hA0, AC = 12'hA4, AS = 12'hA8;

  cfg_xact_engine i_cfg_xact_engine (
    .clk(clk), .rst_n(rst_n), .cfg_present(cfg_present), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .shutdown_req(shutdown_req), .reboot_req(reboot_req));

  always #10 clk = ~clk;

  function automatic logic [31:0] mk(input logic w, input logic [3:0] dcc,
      input logic [5:0] fn, input logic [1:0] site, input logic [3:0] pos,
      input logic [11:0] dev);
    return {1'b1, w, dcc, fn, 2'b00, site, pos, dev};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic xact(input logic [31:0] c);
    bwrite(AC, c);
    @(posedge clk);
    #1 seen_sd = shutdown_req; seen_rb = reboot_req;
  endtask

  task automatic t_reset;
    bread(AD, rd); chk("R1 data", rd, 0);
    bread(AC, rd); chk("R1 ctrl", rd, 0);
    bread(AS, rd); chk("R1 stat", rd, 0);
    chk("R1 reqs", {30'd0, shutdown_req, reboot_req}, 0);
    xact(mk(0, 0, 1, 0, 0, 0)); bread(AD, rd); chk("R1 osc0", rd, 50000000);
    xact(mk(0, 0, 1, 0, 0, 1)); bread(AD, rd); chk("R1 osc1", rd, 23750000);
    xact(mk(0, 0, 1, 0, 0, 5)); bread(AD, rd); chk("R1 osc5", rd, 24000000);
  endtask

  task automatic t_ctrl_mask;
    bwrite(AS, 32'h2);
    bwrite(AC, 32'h7FFF_FFFF);
    @(negedge clk);
    bread(AC, rd); chk("R2 mask", rd, 32'h7FF3_FFFF);
    bread(AS, rd); chk("R2 no launch", rd, 2);
    xact(mk(0, 0, 1, 0, 0, 2));
    bread(AC, rd); chk("R2 start reads zero", rd[31], 0);
    bread(AS, rd); chk("R3 complete", rd, 1);
  endtask

  task automatic t_errors;
    bwrite(AD, 32'h1234);
    xact(mk(0, 1, 1, 0, 0, 0)); bread(AS, rd); chk("R4 dcc", rd, 3);
    xact(mk(0, 0, 1, 0, 1, 0)); bread(AS, rd); chk("R4 pos", rd, 3);
    xact(mk(0, 0, 1, 2, 0, 0)); bread(AS, rd); chk("R4 site2", rd, 3);
    xact(mk(0, 0, 3, 0, 0, 0)); bread(AS, rd); chk("R4 fn3", rd, 3);
    bread(AD, rd); chk("R9 failed read keeps data", rd, 32'h1234);
  endtask

  task automatic t_mb_osc;
    bwrite(AD, 32'd777);
    xact(mk(1, 0, 1, 0, 0, 3)); bread(AS, rd); chk("R5 write ok", rd, 1);
    bwrite(AD, 0);
    xact(mk(0, 0, 1, 0, 0, 3)); bread(AD, rd); chk("R9 write uses data", rd, 777);
    xact(mk(0, 0, 1, 0, 0, 6)); bread(AS, rd); chk("R5 dev6", rd, 3);
  endtask

  task automatic t_db_osc;
    xact(mk(0, 0, 1, 1, 0, 0)); bread(AD, rd); chk("R6 db0", rd, 30000000);
    xact(mk(0, 0, 1, 1, 0, 1)); bread(AD, rd); chk("R6 db1", rd, 45000000);
    bwrite(AD, 32'd99);
    xact(mk(1, 0, 1, 1, 0, 1));
    xact(mk(0, 0, 1, 1, 0, 1)); bread(AD, rd); chk("R6 db1 written", rd, 99);
    xact(mk(0, 0, 1, 1, 0, 2)); bread(AS, rd); chk("R6 db2 error", rd, 3);
  endtask

  task automatic t_volt;
    xact(mk(0, 0, 2, 0, 0, 0)); bread(AD, rd); chk("R7 mb supply", rd, 3300000);
    xact(mk(0, 0, 2, 1, 0, 1)); bread(AD, rd); chk("R7 db volt1", rd, 1000000);
    xact(mk(0, 0, 2, 0, 0, 1)); bread(AS, rd); chk("R7 mb dev1", rd, 3);
    xact(mk(1, 0, 2, 0, 0, 0)); bread(AS, rd); chk("R7 write", rd, 3);
  endtask

  task automatic t_ctl_funcs;
    xact(mk(1, 0, 8, 0, 0, 0));
    chk("R8 shutdown pulse", {30'd0, seen_sd, seen_rb}, 2);
    @(posedge clk); #1 chk("R8 shutdown one cycle", shutdown_req, 0);
    xact(mk(1, 0, 9, 0, 0, 0));
    chk("R8 reboot pulse", {30'd0, seen_sd, seen_rb}, 1);
    @(posedge clk); #1 chk("R8 reboot one cycle", reboot_req, 0);
    xact(mk(1, 0, 7, 0, 0, 0)); bread(AS, rd); chk("R8 fn7", rd, 1);
    chk("R8 fn7 no pulse", {30'd0, seen_sd, seen_rb}, 0);
    xact(mk(1, 0, 11, 0, 0, 0)); bread(AS, rd); chk("R8 fn11", rd, 1);
    xact(mk(1, 0, 8, 1, 0, 0)); bread(AS, rd); chk("R8 site1 err", rd, 3);
    chk("R8 site1 no pulse", {30'd0, seen_sd, seen_rb}, 0);
    xact(mk(0, 0, 9, 0, 0, 0)); bread(AS, rd); chk("R8 read err", rd, 3);
    chk("R8 read no pulse", {30'd0, seen_sd, seen_rb}, 0);
  endtask

  task automatic t_stat_write;
    bwrite(AS, 32'hFFFF_FFFE); bread(AS, rd); chk("R10 low bits", rd, 2);
    bwrite(AS, 32'h0000_0001); bread(AS, rd); chk("R10 low bits b", rd, 1);
  endtask

  task automatic t_collision;
    bwrite(AC, mk(0, 0, 1, 0, 0, 0));
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AD; bus_wdata = 32'hDEAD;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    bread(AD, rd); chk("R11 read result wins", rd, 50000000);
    bwrite(AC, mk(0, 1, 1, 0, 0, 0));
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AS; bus_wdata = 0;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    bread(AS, rd); chk("R11 status wins", rd, 3);
    bwrite(AC, mk(0, 1, 1, 0, 0, 0));
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AD; bus_wdata = 32'h55;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    bread(AD, rd); chk("R11 sw data on error", rd, 32'h55);
  endtask

  task automatic t_absent;
    logic [31:0] d0, c0;
    bread(AD, d0); bread(AC, c0);
    cfg_present = 1'b0;
    bread(AD, rd); chk("R12 reads zero", rd, 0);
    bwrite(AD, 32'hABC);
    xact(mk(1, 0, 8, 0, 0, 0));
    chk("R12 no pulse", {30'd0, seen_sd, seen_rb}, 0);
    cfg_present = 1'b1;
    bread(AD, rd); chk("R12 data kept", rd, d0);
    bread(AC, rd); chk("R12 ctrl kept", rd, c0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl_mask;
    t_errors;
    t_mb_osc;
    t_db_osc;
    t_volt;
    t_ctl_funcs;
    t_stat_write;
    t_collision;
    t_absent;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule